// File: doc/BRIEF.md
# Exception Dispatch Unit

The unit takes exception requests from a processor core and turns each one into the architectural state updates that must happen before the core fetches the handler. It also produces a one-cycle vector-select pulse with a vector code. The unit owns the status fields it needs: the exception-mode flag, the user-mode flag and the interrupt level. It also owns the saved-PC registers, the cause register, the faulting-address register, the debug-cause register, and a small per-level store of saved PCs and saved status words.

There are two kinds of request. A general request carries a PC and a cause code, and it can also carry a faulting virtual address. A debug request carries a PC and a debug cause. It is taken only when the current interrupt level is below the configured debug level.

Both kinds of request are registered on arrival and applied on the following clock edge. At that edge the unit picks one of four vectors: kernel, user, double or debug. A configuration parameter decides whether the PC of a double exception goes to a dedicated double-exception PC register or to the first-level PC register. The core can load the status fields through a write port, for example when it returns from a handler.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, the outputs hold these values. Exception-mode is 1, user-mode is 0 and the interrupt level is 0. The PC, double PC, cause, address and debug-cause registers are all 0. The vector strobe is low. Every entry of the per-level store reads 0.
- R2: A general request taken with exception-mode 0 and user-mode 1 behaves as follows. It produces vector code 1 (user) and saves the request PC into the first-level PC register.
- R3: A general request taken with exception-mode 0 and user-mode 0 behaves as follows. It produces vector code 0 (kernel) and saves the request PC into the first-level PC register.
- R4: A general request taken with exception-mode 1 produces vector code 2 (double). With HAS_DEPC=1 the PC goes to the double PC register and the first-level PC register keeps its value. With HAS_DEPC=0 the PC goes to the first-level PC register.
- R5: Every taken general request loads the cause register with the request cause and leaves exception-mode at 1.
- R6: A general request flagged as carrying an address loads the faulting-address register with the request address. A general request without the flag leaves that register unchanged.
- R7: A debug request is taken only when the interrupt level is below DEBUG_LEVEL. A masked debug request that arrives alone gives no strobe and changes no state.
- R8: A taken debug request updates state as follows:
  - It loads the debug-cause register.
  - It writes the PC into the per-level store at index DEBUG_LEVEL.
  - It writes the old status word into the store at the same index. The status word is packed as [5:2]=interrupt level, [1]=user-mode, [0]=exception-mode.
  - It sets the interrupt level to DEBUG_LEVEL, sets exception-mode to 1 and leaves user-mode unchanged.
  - It produces vector code 3 (debug).
- R9: When a debug request and a general request arrive in the same cycle, a taken debug request wins and the general request leaves no trace. If the debug request is masked, the general request is taken.
- R10: A request sampled at clock edge k raises the strobe and updates state at edge k+1. Without a further request, the strobe is low again after edge k+2.
- R11: A status write loads the three status fields on the next edge from the same packing as in R8. A request applied at that edge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_req | input | 1 | General exception request |
| gen_has_addr | input | 1 | General request carries a faulting address |
| req_pc | input | PC_W | PC of the excepting instruction |
| req_cause | input | CAUSE_W | General cause code |
| req_vaddr | input | PC_W | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| ps_wr | input | 1 | Status write strobe |
| ps_wdata | input | LVL_W+2 | Status word to write |
| lvl_sel | input | LVL_W | Per-level store read index |
| vec_strobe | output | 1 | One-cycle vector-select pulse |
| vec_code | output | 3 | Selected vector code |
| excm | output | 1 | Exception-mode flag |
| um | output | 1 | User-mode flag |
| intlevel | output | LVL_W | Current interrupt level |
| epc1 | output | PC_W | First-level saved PC |
| depc | output | PC_W | Double-exception saved PC |
| exccause | output | CAUSE_W | Cause register |
| excvaddr | output | PC_W | Faulting-address register |
| dbgcause | output | DCAUSE_W | Debug-cause register |
| lvl_pc | output | PC_W | Saved PC read from the per-level store (one cycle after lvl_sel) |
| lvl_ps | output | LVL_W+2 | Saved status read from the per-level store |

## Verification
Random status words are written before each request so that the vector choice is exercised across all four combinations of exception-mode and user-mode. Interrupt levels are drawn on both sides of the debug level. These cases separate the kernel, user and double vectors, and they separate masked from taken debug requests. The address flag is randomized so that a leaked address write shows up in the faulting-address register. Directed cases cover a debug and a general request in the same cycle, once with the level below the debug level and once above it. This shows whether the debug request wins and whether a masked one lets the general request through. A readback of the per-level store after each taken debug request confirms both the saved PC and the saved status word.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    VEC_KERNEL = 3'd0,
    VEC_USER   = 3'd1,
    VEC_DOUBLE = 3'd2,
    VEC_DEBUG  = 3'd3
  } vec_e;
endpackage

// File: rtl/exc_req_stage.sv
module exc_req_stage #(
  parameter int PC_W     = 32,
  parameter int CAUSE_W  = 6,
  parameter int DCAUSE_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gen_req,
  input  logic                gen_has_addr,
  input  logic [PC_W-1:0]     req_pc,
  input  logic [CAUSE_W-1:0]  req_cause,
  input  logic [PC_W-1:0]     req_vaddr,
  input  logic                dbg_req,
  input  logic [DCAUSE_W-1:0] dbg_cause,
  output logic                gen_q,
  output logic                addr_q,
  output logic [PC_W-1:0]     pc_q,
  output logic [CAUSE_W-1:0]  cause_q,
  output logic [PC_W-1:0]     vaddr_q,
  output logic                dbg_q,
  output logic [DCAUSE_W-1:0] dcause_q
);
  // Only the valid bits are reset; the payload follows them.
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q  <= 1'b0;
      dbg_q  <= 1'b0;
      addr_q <= 1'b0;
    end else begin
      gen_q  <= gen_req;
      dbg_q  <= dbg_req;
      addr_q <= gen_req & gen_has_addr;
    end
  end

  always_ff @(posedge clk) begin
    pc_q     <= req_pc;
    cause_q  <= req_cause;
    vaddr_q  <= req_vaddr;
    dcause_q <= dbg_cause;
  end
endmodule

// File: rtl/exc_decide.sv
module exc_decide
  import exc_pkg::*;
#(
  parameter int LVL_W       = 4,
  parameter int DEBUG_LEVEL = 6
) (
  input  logic             gen_v,
  input  logic             dbg_v,
  input  logic             excm,
  input  logic             um,
  input  logic [LVL_W-1:0] intlevel,
  output logic             take_dbg,
  output logic             take_gen,
  output vec_e             code
);
  localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DEBUG_LEVEL);

  always_comb begin
    take_dbg = dbg_v && (intlevel < DBG_LVL);
    take_gen = gen_v && !take_dbg;
    if (take_dbg)  code = VEC_DEBUG;
    else if (excm) code = VEC_DOUBLE;
    else if (um)   code = VEC_USER;
    else           code = VEC_KERNEL;
  end
endmodule

// File: rtl/exc_level_store.sv
module exc_level_store #(
  parameter int LVL_W = 4,
  parameter int PC_W  = 32,
  parameter int PS_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LVL_W-1:0] wlvl,
  input  logic [PC_W-1:0]  wpc,
  input  logic [PS_W-1:0]  wps,
  input  logic [LVL_W-1:0] rsel,
  output logic [PC_W-1:0]  rpc,
  output logic [PS_W-1:0]  rps
);
  localparam int DEPTH = 1 << LVL_W;

  logic [PC_W-1:0] pc_mem [DEPTH];
  logic [PS_W-1:0] ps_mem [DEPTH];

  // Small store: cleared on reset so every saved level reads zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        pc_mem[i] <= '0;
        ps_mem[i] <= '0;
      end
    end else if (we) begin
      pc_mem[wlvl] <= wpc;
      ps_mem[wlvl] <= wps;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rpc <= '0;
      rps <= '0;
    end else begin
      rpc <= pc_mem[rsel];
      rps <= ps_mem[rsel];
    end
  end
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 6,
  parameter int LVL_W       = 4,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  gen_req,
  input  logic                  gen_has_addr,
  input  logic [PC_W-1:0]       req_pc,
  input  logic [CAUSE_W-1:0]    req_cause,
  input  logic [PC_W-1:0]       req_vaddr,
  input  logic                  dbg_req,
  input  logic [DCAUSE_W-1:0]   dbg_cause,
  input  logic                  ps_wr,
  input  logic [LVL_W+1:0]      ps_wdata,
  input  logic [LVL_W-1:0]      lvl_sel,
  output logic                  vec_strobe,
  output logic [2:0]            vec_code,
  output logic                  excm,
  output logic                  um,
  output logic [LVL_W-1:0]      intlevel,
  output logic [PC_W-1:0]       epc1,
  output logic [PC_W-1:0]       depc,
  output logic [CAUSE_W-1:0]    exccause,
  output logic [PC_W-1:0]       excvaddr,
  output logic [DCAUSE_W-1:0]   dbgcause,
  output logic [PC_W-1:0]       lvl_pc,
  output logic [LVL_W+1:0]      lvl_ps
);
  localparam int PS_W = LVL_W + 2;
  localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DEBUG_LEVEL);

  logic                gen_q, addr_q, dbg_q;
  logic [PC_W-1:0]     pc_q, vaddr_q;
  logic [CAUSE_W-1:0]  cause_q;
  logic [DCAUSE_W-1:0] dcause_q;
  logic                take_dbg, take_gen;
  vec_e                code;
  logic [PS_W-1:0]     ps_now;

  assign ps_now = {intlevel, um, excm};

  exc_req_stage #(.PC_W(PC_W), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W)) u_req (
    .clk(clk), .rst(rst),
    .gen_req(gen_req), .gen_has_addr(gen_has_addr),
    .req_pc(req_pc), .req_cause(req_cause), .req_vaddr(req_vaddr),
    .dbg_req(dbg_req), .dbg_cause(dbg_cause),
    .gen_q(gen_q), .addr_q(addr_q), .pc_q(pc_q), .cause_q(cause_q),
    .vaddr_q(vaddr_q), .dbg_q(dbg_q), .dcause_q(dcause_q)
  );

  exc_decide #(.LVL_W(LVL_W), .DEBUG_LEVEL(DEBUG_LEVEL)) u_dec (
    .gen_v(gen_q), .dbg_v(dbg_q),
    .excm(excm), .um(um), .intlevel(intlevel),
    .take_dbg(take_dbg), .take_gen(take_gen), .code(code)
  );

  exc_level_store #(.LVL_W(LVL_W), .PC_W(PC_W), .PS_W(PS_W)) u_lvl (
    .clk(clk), .rst(rst),
    .we(take_dbg), .wlvl(DBG_LVL), .wpc(pc_q), .wps(ps_now),
    .rsel(lvl_sel), .rpc(lvl_pc), .rps(lvl_ps)
  );

  // Status, cause and first-level PC
  always_ff @(posedge clk) begin
    if (rst) begin
      vec_strobe <= 1'b0;
      vec_code   <= VEC_KERNEL;
      excm       <= 1'b1;
      um         <= 1'b0;
      intlevel   <= '0;
      epc1       <= '0;
      exccause   <= '0;
      excvaddr   <= '0;
      dbgcause   <= '0;
    end else begin
      vec_strobe <= take_dbg | take_gen;
      if (take_dbg | take_gen) vec_code <= code;
      if (take_dbg) begin
        dbgcause <= dcause_q;
        intlevel <= DBG_LVL;
        excm     <= 1'b1;
      end else if (take_gen) begin
        exccause <= cause_q;
        excm     <= 1'b1;
        if (addr_q) excvaddr <= vaddr_q;
        if (!excm || !HAS_DEPC) epc1 <= pc_q;
      end else if (ps_wr) begin
        {intlevel, um, excm} <= ps_wdata;
      end
    end
  end

  // Double-exception PC register exists only when configured
  generate
    if (HAS_DEPC) begin : g_depc
      logic [PC_W-1:0] depc_r;
      always_ff @(posedge clk) begin
        if (rst)                  depc_r <= '0;
        else if (take_gen && excm) depc_r <= pc_q;
      end
      assign depc = depc_r;
    end else begin : g_no_depc
      assign depc = '0;
    end
  endgenerate
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk #(
  parameter int LVL_W       = 4,
  parameter int CAUSE_W     = 6,
  parameter int DEBUG_LEVEL = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               gen_req,
  input logic               dbg_req,
  input logic               vec_strobe,
  input logic [2:0]         vec_code,
  input logic               excm,
  input logic               um,
  input logic [LVL_W-1:0]   intlevel,
  input logic [CAUSE_W-1:0] exccause
);
  // R10
  strobe_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    vec_strobe |-> $past(gen_req || dbg_req, 2));
  // R5
  excm_set_after_vector_chk: assert property (@(posedge clk) disable iff (rst)
    vec_strobe |-> excm);
  // R4
  double_needs_excm_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_strobe && vec_code == 3'd2) |-> $past(excm));
  // R3
  kernel_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_strobe && vec_code == 3'd0) |-> (!$past(excm) && !um));
  // R2
  user_needs_um_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_strobe && vec_code == 3'd1) |-> (!$past(excm) && um));
  // R8
  debug_level_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_strobe && vec_code == 3'd3) |-> (intlevel == LVL_W'(DEBUG_LEVEL)));
  // R7
  debug_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_strobe && vec_code == 3'd3) |-> ($past(intlevel) < LVL_W'(DEBUG_LEVEL)));
  // R9
  cause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !vec_strobe |-> $stable(exccause));
  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    vec_strobe |-> (vec_code <= 3'd3));
endmodule

bind exc_dispatch exc_dispatch_chk #(
  .LVL_W(LVL_W), .CAUSE_W(CAUSE_W), .DEBUG_LEVEL(DEBUG_LEVEL)
) u_chk (
  .clk(clk), .rst(rst), .gen_req(gen_req), .dbg_req(dbg_req),
  .vec_strobe(vec_strobe), .vec_code(vec_code), .excm(excm), .um(um),
  .intlevel(intlevel), .exccause(exccause)
);

// File: tb/sim_exc_dispatch.sv
`timescale 1ns/1ps
module sim_exc_dispatch;
  localparam int DBG = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic        gen_req, gen_has_addr, dbg_req, ps_wr;
  logic [31:0] req_pc, req_vaddr;
  logic [5:0]  req_cause, dbg_cause, ps_wdata;
  logic [3:0]  lvl_sel;
  logic        vec_strobe, excm, um;
  logic [2:0]  vec_code;
  logic [3:0]  intlevel;
  logic [31:0] epc1, depc, excvaddr, lvl_pc;
  logic [5:0]  exccause, dbgcause, lvl_ps;

  int n_run = 0;
  int n_fail = 0;

  // model state
  logic        m_excm, m_um;
  logic [3:0]  m_il;
  logic [31:0] m_epc1, m_depc, m_vaddr, m_lpc;
  logic [5:0]  m_cause, m_dcause, m_lps;

  always #2.5 clk = ~clk;

  exc_dispatch u0 (
    .clk(clk), .rst(rst), .gen_req(gen_req), .gen_has_addr(gen_has_addr),
    .req_pc(req_pc), .req_cause(req_cause), .req_vaddr(req_vaddr),
    .dbg_req(dbg_req), .dbg_cause(dbg_cause), .ps_wr(ps_wr), .ps_wdata(ps_wdata),
    .lvl_sel(lvl_sel), .vec_strobe(vec_strobe), .vec_code(vec_code),
    .excm(excm), .um(um), .intlevel(intlevel), .epc1(epc1), .depc(depc),
    .exccause(exccause), .excvaddr(excvaddr), .dbgcause(dbgcause),
    .lvl_pc(lvl_pc), .lvl_ps(lvl_ps)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " excm"}, 32'(excm), 32'(m_excm));
    chk({tag, " um"}, 32'(um), 32'(m_um));
    chk({tag, " intlevel"}, 32'(intlevel), 32'(m_il));
    chk({tag, " epc1"}, epc1, m_epc1);
    chk({tag, " depc"}, depc, m_depc);
    chk({tag, " R5 cause"}, 32'(exccause), 32'(m_cause));
    chk({tag, " R6 vaddr"}, excvaddr, m_vaddr);
    chk({tag, " dbgcause"}, 32'(dbgcause), 32'(m_dcause));
  endtask

  // R11: status write
  task automatic write_ps(input logic [5:0] v);
    @(negedge clk);
    ps_wr = 1'b1; ps_wdata = v;
    @(negedge clk);
    ps_wr = 1'b0;
    {m_il, m_um, m_excm} = v;
    chk("R11 ps readback", 32'({intlevel, um, excm}), 32'(v));
  endtask

  function automatic string path_tag(input bit td, input bit tg, input logic ex, input logic u);
    if (td) return "R8";
    if (!tg) return "R7";
    if (ex) return "R4";
    return u ? "R2" : "R3";
  endfunction

  task automatic do_req(input bit g, input bit d, input bit a, input logic [31:0] pc,
                        input logic [5:0] c, input logic [31:0] va, input logic [5:0] dc,
                        input string extra);
    bit td, tg;
    logic [2:0] ecode;
    string tag;
    td = d && (m_il < 4'(DBG));
    tg = g && !td;
    ecode = td ? 3'd3 : (m_excm ? 3'd2 : (m_um ? 3'd1 : 3'd0));
    tag = {path_tag(td, tg, m_excm, m_um), extra};
    if (td) begin
      m_lpc = pc; m_lps = {m_il, m_um, m_excm};
      m_dcause = dc; m_il = 4'(DBG); m_excm = 1'b1;
    end else if (tg) begin
      if (m_excm) m_depc = pc; else m_epc1 = pc;
      m_cause = c;
      if (a) m_vaddr = va;
      m_excm = 1'b1;
    end
    @(negedge clk);
    gen_req = g; dbg_req = d; gen_has_addr = a;
    req_pc = pc; req_cause = c; req_vaddr = va; dbg_cause = dc;
    @(negedge clk);
    gen_req = 1'b0; dbg_req = 1'b0; gen_has_addr = 1'b0;
    @(negedge clk);
    chk({tag, " R10 strobe"}, 32'(vec_strobe), 32'(td | tg));
    if (td | tg) chk({tag, " code"}, 32'(vec_code), 32'(ecode));
    check_state(tag);
    @(negedge clk);
    chk("R10 strobe drop", 32'(vec_strobe), 32'd0);
    if (td) begin
      lvl_sel = 4'(DBG);
      @(negedge clk);
      chk("R8 saved pc", lvl_pc, m_lpc);
      chk("R8 saved ps", 32'(lvl_ps), 32'(m_lps));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    gen_req = 0; dbg_req = 0; gen_has_addr = 0; ps_wr = 0;
    req_pc = 0; req_cause = 0; req_vaddr = 0; dbg_cause = 0; ps_wdata = 0;
    lvl_sel = 4'(DBG);
    m_excm = 1; m_um = 0; m_il = 0; m_epc1 = 0; m_depc = 0; m_vaddr = 0;
    m_cause = 0; m_dcause = 0; m_lpc = 0; m_lps = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check_state("R1");
    chk("R1 strobe", 32'(vec_strobe), 32'd0);
    chk("R1 store pc", lvl_pc, 32'd0);
    chk("R1 store ps", 32'(lvl_ps), 32'd0);

    // Directed corners
    do_req(1, 0, 1, 32'h1000_0040, 6'd9, 32'hdead_0000, 6'd0, " first");   // R4 double from reset
    write_ps(6'b0000_10);                                               // um=1, excm=0
    do_req(1, 0, 0, 32'h2000_0004, 6'd3, 32'h1111_1111, 6'd0, " user"); // R2, R6 no addr
    write_ps(6'b0010_00);                                               // kernel, il=2
    do_req(1, 1, 1, 32'h3000_0008, 6'd5, 32'h2222_2222, 6'd7, " R9 win");
    write_ps(6'b0111_00);                                               // il=7, masked
    do_req(0, 1, 0, 32'h4000_000c, 6'd1, 32'h0, 6'd2, " masked");       // R7
    do_req(1, 1, 0, 32'h5000_0010, 6'd4, 32'h0, 6'd3, " R9 masked");    // general goes through
    write_ps(6'b0110_00);                                               // il=6 == debug level
    do_req(0, 1, 0, 32'h5500_0000, 6'd1, 32'h0, 6'd6, " boundary");     // R7
    write_ps(6'b0101_00);                                               // il=5 < debug level
    do_req(0, 1, 0, 32'h5600_0000, 6'd1, 32'h0, 6'd6, " below");        // R8

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0] ps;
      ps = 6'($urandom);
      if (($urandom % 4) != 0) write_ps(ps);
      do_req(bit'($urandom), bit'($urandom), bit'($urandom), $urandom,
             6'($urandom), $urandom, 6'($urandom), " rnd");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule